// File: doc/BRIEF.md
# Row/Column Decoded Word Memory

This block is a small word-addressed RAM of sixteen 16-bit cells. It is never read or written directly. Each access passes through an address staging register and a data staging register. The staged address is split in two: a row decoder drives the upper bits and a column decoder drives the lower bits. The one cell where the active row line crosses the active column line is the only cell enabled.

A client pulses `start` with the operation bit, the address and, for a store, the data word. The access then runs as a fixed sequence of one clock per step. A fetch has three steps: stage the address, decode it, copy the cell into the data register. A store has four steps: stage the address, stage the data, decode, write the data register into the cell. A one-cycle `done` pulse marks the end of either sequence. The data register drives `mdrOut` at all times.

Top module: `memGrid`

## Requirements
- R1: Address bits [3:2] select one of four rows and bits [1:0] select one of four columns, in row-major order, so address 4'b0010 is row 0, column 2. All sixteen addresses reach sixteen distinct cells.
- R2: A store writes only the cell at the crossing of the selected row and column. Every other cell keeps its contents.
- R3: A fetch is requested with `opStore`=0. If `start` is sampled high at clock edge k, then in the cycle after edge k+2 `done` is high and `mdrOut` holds the addressed cell.
- R4: A fetch leaves the cell unchanged. Fetching the same address again returns the same word.
- R5: A store is requested with `opStore`=1. `addrIn` is captured at edge k and `dataIn` at edge k+1. The cell is written at edge k+3, and `done` is high in the cycle after edge k+3, with `mdrOut` equal to the stored word.
- R6: A store replaces the whole 16-bit word. No bit of the old contents survives, whether it was 16'hFFFF or 16'h0000 before.
- R7: `done` is high for exactly one cycle per accepted operation and is low at all other times.
- R8: A `start` that arrives while an operation is in progress is ignored. The running operation completes with its own address and data, no extra `done` follows, and the ignored request touches no cell.
- R9: The active-low `rstN` clears the address register, the data register and all cells to zero, including when it interrupts an operation. After reset `mdrOut` is 0, `done` is 0 and every cell fetches as 0.
- R10: A `start` in the same cycle that `done` is high is accepted, because the block is idle in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, accepted only when idle |
| opStore | input | 1 | Operation select: 0 = fetch, 1 = store |
| addrIn | input | 4 | Cell address, captured at the start edge |
| dataIn | input | 16 | Store word, captured one edge after start |
| mdrOut | output | 16 | Contents of the data staging register |
| done | output | 1 | One-cycle completion pulse |

## Verification
Counting from the edge that samples `start`, the fetch result and `done` are due in the cycle after the third edge, and the store `done` in the cycle after the fourth. The bench drives inputs and samples outputs on falling edges. After each request it counts falling edges and records the index at which `done` appears, the number of times it appears, and `mdrOut` at that point, then compares them with index 2 for a fetch and index 3 for a store. The ignored-start, back-to-back and mid-operation reset cases use the same edge counting, so that the extra request lands on a known step of the running sequence.

// File: rtl/memGridPkg.sv
package memGridPkg;

  // Per-cycle strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadMar;    // capture address into staging register
    logic loadMdrIn;  // capture store word into data register
    logic latchDec;   // register row/column decoder outputs
    logic clearDec;   // drop all select lines
    logic readCell;   // copy crossing cell into data register
    logic writeCell;  // copy data register into crossing cell
  } gridStb_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LDMDR,
    ST_DECODE,
    ST_XFER
  } gridState_t;

endpackage

// File: rtl/memGridDec.sv
module memGridDec #(
  parameter int IN_W = 2,
  localparam int OUT_N = 1 << IN_W
) (
  input  logic [IN_W-1:0]  code,
  output logic [OUT_N-1:0] lines
);

  for (genvar g = 0; g < OUT_N; g++) begin : g_line
    assign lines[g] = (code == IN_W'(g));
  end

endmodule

// File: rtl/memGridPath.sv
module memGridPath
  import memGridPkg::*;
#(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  parameter int DATA_W   = 16,
  localparam int ADDR_W    = ROW_BITS + COL_BITS,
  localparam int ROWS      = 1 << ROW_BITS,
  localparam int COLS      = 1 << COL_BITS,
  localparam int NUM_CELLS = ROWS * COLS
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  gridStb_t                      stb,
  input  logic [ADDR_W-1:0]             addrIn,
  input  logic [DATA_W-1:0]             dataIn,
  output logic [DATA_W-1:0]             mdrQ,
  output logic [ADDR_W-1:0]             marQ,
  output logic [ROWS-1:0]               rowSelQ,
  output logic [COLS-1:0]               colSelQ,
  output logic [NUM_CELLS-1:0]          crossFlat,
  output logic [NUM_CELLS*DATA_W-1:0]   cellFlat
);

  logic [ROWS-1:0] rowLines;
  logic [COLS-1:0] colLines;
  logic [NUM_CELLS-1:0][DATA_W-1:0] cellArr;
  logic [DATA_W-1:0] rdWord;

  // Address staging register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            marQ <= '0;
    else if (stb.loadMar) marQ <= addrIn;
  end

  // Separate decoders for the row and column halves of the address
  memGridDec #(.IN_W(ROW_BITS)) i_rowDec (
    .code  (marQ[ADDR_W-1:COL_BITS]),
    .lines (rowLines)
  );

  memGridDec #(.IN_W(COL_BITS)) i_colDec (
    .code  (marQ[COL_BITS-1:0]),
    .lines (colLines)
  );

  // Registered select lines, live only for the transfer step
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowSelQ <= '0;
      colSelQ <= '0;
    end else if (stb.latchDec) begin
      rowSelQ <= rowLines;
      colSelQ <= colLines;
    end else if (stb.clearDec) begin
      rowSelQ <= '0;
      colSelQ <= '0;
    end
  end

  // Crosspoint enables, row-major numbering
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      assign crossFlat[r*COLS + c] = rowSelQ[r] & colSelQ[c];
    end
  end

  // Cell array: whole-word writes at the enabled crosspoint only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cellArr <= '0;
    end else if (stb.writeCell) begin
      for (int i = 0; i < NUM_CELLS; i++) begin
        if (crossFlat[i]) cellArr[i] <= mdrQ;
      end
    end
  end

  // Read path: AND-OR over the crosspoints
  always_comb begin
    rdWord = '0;
    for (int i = 0; i < NUM_CELLS; i++) begin
      if (crossFlat[i]) rdWord = rdWord | cellArr[i];
    end
  end

  // Data staging register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              mdrQ <= '0;
    else if (stb.loadMdrIn) mdrQ <= dataIn;
    else if (stb.readCell)  mdrQ <= rdWord;
  end

  assign cellFlat = cellArr;

endmodule

// File: rtl/memGridCtrl.sv
module memGridCtrl
  import memGridPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     opStore,
  output gridStb_t stb,
  output logic     busy,
  output logic     done
);

  gridState_t state, stateNxt;
  logic opQ;

  always_comb begin
    stb      = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          stb.loadMar = 1'b1;
          stateNxt    = opStore ? ST_LDMDR : ST_DECODE;
        end
      end
      ST_LDMDR: begin
        stb.loadMdrIn = 1'b1;
        stateNxt      = ST_DECODE;
      end
      ST_DECODE: begin
        stb.latchDec = 1'b1;
        stateNxt     = ST_XFER;
      end
      ST_XFER: begin
        stb.writeCell = opQ;
        stb.readCell  = ~opQ;
        stb.clearDec  = 1'b1;
        stateNxt      = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      opQ   <= 1'b0;
      done  <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= (state == ST_XFER);
      if (state == ST_IDLE && start) opQ <= opStore;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/memGrid.sv
module memGrid
  import memGridPkg::*;
#(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  parameter int DATA_W   = 16,
  localparam int ADDR_W    = ROW_BITS + COL_BITS,
  localparam int NUM_CELLS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              opStore,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] mdrOut,
  output logic              done
);

  gridStb_t stb;
  logic busy;
  logic [ADDR_W-1:0] marQ;
  logic [(1<<ROW_BITS)-1:0] rowSelQ;
  logic [(1<<COL_BITS)-1:0] colSelQ;
  logic [NUM_CELLS-1:0] crossFlat;
  logic [NUM_CELLS*DATA_W-1:0] cellFlat;

  memGridCtrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .opStore (opStore),
    .stb     (stb),
    .busy    (busy),
    .done    (done)
  );

  memGridPath #(
    .ROW_BITS (ROW_BITS),
    .COL_BITS (COL_BITS),
    .DATA_W   (DATA_W)
  ) i_path (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .addrIn    (addrIn),
    .dataIn    (dataIn),
    .mdrQ      (mdrOut),
    .marQ      (marQ),
    .rowSelQ   (rowSelQ),
    .colSelQ   (colSelQ),
    .crossFlat (crossFlat),
    .cellFlat  (cellFlat)
  );

endmodule

// File: rtl/memGridChk.sv
module memGridChk #(
  parameter int ROWS      = 4,
  parameter int COLS      = 4,
  parameter int ADDR_W    = 4,
  parameter int NUM_CELLS = 16,
  parameter int DATA_W    = 16
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        busy,
  input logic                        done,
  input logic [ADDR_W-1:0]           marQ,
  input logic [ROWS-1:0]             rowSelQ,
  input logic [COLS-1:0]             colSelQ,
  input logic [NUM_CELLS-1:0]        crossFlat,
  input logic [NUM_CELLS*DATA_W-1:0] cellFlat
);

  // R1
  row_col_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rowSelQ) && $onehot0(colSelQ));

  // R2
  single_cross_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(crossFlat));

  // R4
  cell_change_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cellFlat) |-> done);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  busy_mar_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(marQ));

endmodule

bind memGrid memGridChk #(
  .ROWS      (1 << ROW_BITS),
  .COLS      (1 << COL_BITS),
  .ADDR_W    (ADDR_W),
  .NUM_CELLS (NUM_CELLS),
  .DATA_W    (DATA_W)
) i_memGridChk (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .done      (done),
  .marQ      (marQ),
  .rowSelQ   (rowSelQ),
  .colSelQ   (colSelQ),
  .crossFlat (crossFlat),
  .cellFlat  (cellFlat)
);

// File: tb/test_memGrid.sv
module test_memGrid;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic opStore = 1'b0;
  logic [3:0] addrIn = '0;
  logic [15:0] dataIn = '0;
  logic [15:0] mdrOut;
  logic done;

  int nChk = 0;
  int nBad = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  memGrid i_memGrid (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .opStore (opStore),
    .addrIn  (addrIn),
    .dataIn  (dataIn),
    .mdrOut  (mdrOut),
    .done    (done)
  );

  function automatic logic [15:0] pat(input logic [3:0] a);
    return {a, ~a, a ^ 4'h5, 4'hC};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      summary();
    end
  end

  // Issue one request; idx is the falling edge (0 = right after the start edge)
  // on which done was seen, cnt the number of done cycles in 7 falling edges.
  task automatic runOp(input bit isSt, input logic [3:0] a, input logic [15:0] d,
                       output logic [15:0] got, output int idx, output int cnt);
    @(negedge clk);
    start = 1'b1; opStore = isSt; addrIn = a; dataIn = d;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    idx = -1; cnt = 0; got = '0;
    for (int i = 0; i < 7; i++) begin
      if (done) begin
        cnt++;
        if (idx < 0) begin idx = i; got = mdrOut; end
      end
      if (i < 6) @(negedge clk);
    end
  endtask

  task automatic fetchChk(input logic [3:0] a, input logic [15:0] exp, input string tag);
    logic [15:0] got; int idx; int cnt;
    runOp(1'b0, a, '0, got, idx, cnt);
    check(got == exp, tag, got, exp);
    check(idx == 2, {tag, " fetch latency R3"}, idx, 2);
    check(cnt == 1, {tag, " done count R7"}, cnt, 1);
  endtask

  task automatic storeChk(input logic [3:0] a, input logic [15:0] d, input string tag);
    logic [15:0] got; int idx; int cnt;
    runOp(1'b1, a, d, got, idx, cnt);
    check(got == d, {tag, " mdrOut after store R5"}, got, d);
    check(idx == 3, {tag, " store latency R5"}, idx, 3);
    check(cnt == 1, {tag, " done count R7"}, cnt, 1);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(mdrOut == 16'h0, "R9 mdrOut after reset", mdrOut, 0);
    check(done == 1'b0, "R9 done after reset", done, 0);
    fetchChk(4'h0, 16'h0, "R9 cell 0 after reset");
    fetchChk(4'hF, 16'h0, "R9 cell 15 after reset");
  endtask

  task automatic testAllCells();
    for (int a = 0; a < 16; a++) storeChk(4'(a), pat(4'(a)), "R1 fill");
    for (int a = 0; a < 16; a++) fetchChk(4'(a), pat(4'(a)), "R1 distinct cell");
  endtask

  task automatic testIsolation();
    storeChk(4'b0010, 16'hBEEF, "R2 store addr 2");
    fetchChk(4'b0010, 16'hBEEF, "R2 addr 2 row0 col2");
    fetchChk(4'b0001, pat(4'h1), "R2 neighbour col1");
    fetchChk(4'b0011, pat(4'h3), "R2 neighbour col3");
    fetchChk(4'b0110, pat(4'h6), "R2 neighbour row1 col2");
    fetchChk(4'b1010, pat(4'hA), "R2 neighbour row2 col2");
  endtask

  task automatic testNonDestructive();
    fetchChk(4'h9, pat(4'h9), "R4 first fetch");
    fetchChk(4'h9, pat(4'h9), "R4 second fetch");
    fetchChk(4'h9, pat(4'h9), "R4 third fetch");
  endtask

  task automatic testOverwrite();
    storeChk(4'hC, 16'hFFFF, "R6 ones");
    fetchChk(4'hC, 16'hFFFF, "R6 read ones");
    storeChk(4'hC, 16'h0000, "R6 zeros");
    fetchChk(4'hC, 16'h0000, "R6 read zeros");
    storeChk(4'hC, 16'h5A3C, "R6 mixed");
    fetchChk(4'hC, 16'h5A3C, "R6 read mixed");
  endtask

  task automatic testBusyIgnore();
    int cnt; int idx; logic [15:0] got;
    @(negedge clk);
    start = 1'b1; opStore = 1'b1; addrIn = 4'h5; dataIn = 16'h1234;
    @(posedge clk);
    @(negedge clk);                      // idx 0: busy, MDR load pending
    start = 1'b1; opStore = 1'b0; addrIn = 4'h7;
    cnt = 0; idx = -1; got = '0;
    for (int i = 0; i < 7; i++) begin
      if (i == 2) begin start = 1'b1; opStore = 1'b1; addrIn = 4'hB; dataIn = 16'hDEAD; end
      if (i == 3) start = 1'b0;
      if (i == 1) dataIn = 16'h1234;
      if (done) begin cnt++; if (idx < 0) begin idx = i; got = mdrOut; end end
      if (i < 6) @(negedge clk);
    end
    start = 1'b0;
    check(cnt == 1, "R8 single done despite busy starts", cnt, 1);
    check(idx == 3, "R8 running store latency", idx, 3);
    check(got == 16'h1234, "R8 running store data", got, 16'h1234);
    fetchChk(4'h5, 16'h1234, "R8 target cell written");
    fetchChk(4'hB, pat(4'hB), "R8 ignored store cell untouched");
  endtask

  task automatic testBackToBack();
    int cnt; int firstIdx; int secondIdx; logic [15:0] got;
    @(negedge clk);
    start = 1'b1; opStore = 1'b1; addrIn = 4'hE; dataIn = 16'h0F0F;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cnt = 0; firstIdx = -1; secondIdx = -1; got = '0;
    for (int i = 0; i < 10; i++) begin
      if (i == 4) start = 1'b0;
      if (done) begin
        cnt++;
        if (firstIdx < 0) begin
          firstIdx = i;
          start = 1'b1; opStore = 1'b0; addrIn = 4'hE;
        end else if (secondIdx < 0) begin
          secondIdx = i; got = mdrOut;
        end
      end
      if (i < 9) @(negedge clk);
    end
    start = 1'b0;
    check(firstIdx == 3, "R10 first done index", firstIdx, 3);
    check(secondIdx == 6, "R10 second done index", secondIdx, 6);
    check(got == 16'h0F0F, "R10 back-to-back fetch data", got, 16'h0F0F);
    check(cnt == 2, "R10 done count", cnt, 2);
  endtask

  task automatic testMidReset();
    @(negedge clk);
    start = 1'b1; opStore = 1'b1; addrIn = 4'h0; dataIn = 16'hCAFE;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(mdrOut == 16'h0, "R9 mdrOut after mid-op reset", mdrOut, 0);
    check(done == 1'b0, "R9 done after mid-op reset", done, 0);
    fetchChk(4'h0, 16'h0, "R9 aborted store cell clear");
    fetchChk(4'h5, 16'h0, "R9 written cell cleared");
    fetchChk(4'hE, 16'h0, "R9 other cell cleared");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testAllCells();
    testIsolation();
    testNonDestructive();
    testOverwrite();
    testBusyIgnore();
    testBackToBack();
    testMidReset();
    summary();
  end

endmodule